// File: doc/BRIEF.md
# Serial Peripheral Low-Power Stop Controller

This block holds the configuration and interrupt registers of a serial peripheral subsystem and decides when the subsystem's functional clock runs. A single stop bit in the configuration word gates the clock. While that bit is set, register reads are restricted and register writes are still accepted. A host writes and reads 16-bit words with two byte-lane enables. The block answers reads in the same cycle and commits writes on the rising clock edge.

Before stopping the clock, software must first halt the queued transfer engine. It asserts a halt request and waits for the engine to acknowledge. If stop is set while the engine is still busy and has not acknowledged, the clock is gated anyway and a sticky error flag records the misuse. The enable of the clock gate is taken over only on the falling clock edge, so the gated clock cannot glitch.

Top module: `serStopCtl`

## Requirements
- R1: After reset the configuration word reads 0x8000: stop (bit 15) is set, halt request (bit 14) is clear and the error flag (bit 13) is clear. Interrupt level and vector are 0, and the gated clock is held low.
- R2: The configuration word at word address 0 always reads back, stopped or not. Its bits 12..0 read 0, and so does any address that maps nothing. Configuration writes take effect only with the upper byte-lane enable (regByteEn[1]); a lower-lane-only write leaves it unchanged.
- R3: While stop is set, reads of the interrupt word (address 1), of the queue RAM and of unmapped addresses return 0.
- R4: While stop is set, writes to the interrupt word and to the queue RAM still take effect, and they read back once stop is cleared.
- R5: The interrupt word at address 1 holds a 3-bit level in bits 10..8, written through the upper lane, and an 8-bit vector in bits 7..0, written through the lower lane. A write on one lane leaves the other field unchanged, and bits 15..11 read 0.
- R6: The halt request output follows configuration bit 14 from the cycle after the write.
- R7: A configuration write that changes stop from 0 to 1 while engineBusy is high and haltAck is low sets the error flag, and the clock is still gated. The flag then holds until a configuration write with bit 13 set that does not itself set it again.
- R8: The gate enable is updated only on the falling clock edge to the inverse of stop. gatedClk is low whenever clk is low, and it pulses with clk only while stop is clear.
- R9: Queue RAM word i sits at word address 32+i, for i below RAM_DEPTH. It is written per byte lane and reads back when not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regAddr | input | ADDR_W | Word address |
| regByteEn | input | 2 | Byte-lane enables, bit 1 upper lane |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, same cycle |
| engineBusy | input | 1 | Transfer engine has work in progress |
| haltAck | input | 1 | Transfer engine has halted |
| haltReq | output | 1 | Halt request to the transfer engine |
| gatedClk | output | 1 | Glitch-free gated functional clock |

## Verification
The bench builds the block with its defaults: a 6-bit word address and a 16-word queue RAM. This puts the RAM window at addresses 32 to 47 and leaves addresses 48 to 63 and 2 to 31 unmapped, so the top RAM entry and reads just past it are both reachable. Directed sequences cover writes made while stopped, byte-lane splits, and stopping with and without a prior halt acknowledge. A long pseudo-random mix of stop toggles, lane enables and handshake levels then checks the read data, the halt request and the gated clock against the reference model on every cycle.

// File: rtl/serStopPkg.sv
package serStopPkg;
  typedef struct packed {
    logic wrCfgHi;
    logic wrIntrHi;
    logic wrIntrLo;
    logic wrRamHi;
    logic wrRamLo;
    logic rdCfg;
    logic rdIntr;
    logic rdRam;
  } ctlStrobeT;

  localparam int STOP_POS = 15;
  localparam int HALT_POS = 14;
  localparam int ERR_POS  = 13;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
endpackage

// File: rtl/serStopDecode.sv
module serStopDecode
  import serStopPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int RAM_DEPTH = 16,
  localparam int RAM_AW   = $clog2(RAM_DEPTH),
  localparam int OFF_W    = ADDR_W - 1
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regByteEn,
  input  logic              stopNow,
  output ctlStrobeT         strobes,
  output logic [RAM_AW-1:0] ramIdx
);
  logic isCfg;
  logic isIntr;
  logic isRam;
  logic [OFF_W-1:0] ramOff;

  assign ramOff = regAddr[OFF_W-1:0];
  assign isCfg  = (regAddr == ADDR_W'(0));
  assign isIntr = (regAddr == ADDR_W'(1));
  assign isRam  = regAddr[ADDR_W-1] && (ramOff < OFF_W'(RAM_DEPTH));
  assign ramIdx = regAddr[RAM_AW-1:0];

  always_comb begin
    strobes          = '0;
    // writes are honoured whether or not the clock is stopped
    strobes.wrCfgHi  = regWrEn && isCfg && regByteEn[1];
    strobes.wrIntrHi = regWrEn && isIntr && regByteEn[1];
    strobes.wrIntrLo = regWrEn && isIntr && regByteEn[0];
    strobes.wrRamHi  = regWrEn && isRam && regByteEn[1];
    strobes.wrRamLo  = regWrEn && isRam && regByteEn[0];
    // reads other than configuration are blocked during stop
    strobes.rdCfg    = regRdEn && isCfg;
    strobes.rdIntr   = regRdEn && isIntr && !stopNow;
    strobes.rdRam    = regRdEn && isRam && !stopNow;
  end
endmodule

// File: rtl/serStopRegs.sv
module serStopRegs
  import serStopPkg::*;
#(
  parameter int RAM_DEPTH = 16,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobes,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [15:0]       regWrData,
  input  logic              engineBusy,
  input  logic              haltAck,
  output logic [15:0]       regRdData,
  output logic              stopNow,
  output logic              haltReq,
  output logic              stopErrNow
);
  logic             stopBit;
  logic             haltBit;
  logic             errBit;
  logic [LVL_W-1:0] intrLvl;
  logic [VEC_W-1:0] intrVec;
  logic [15:0]      queueMem [RAM_DEPTH];
  logic             badStop;

  assign badStop = !stopBit && regWrData[STOP_POS] && engineBusy && !haltAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit <= 1'b1;
      haltBit <= 1'b0;
      errBit  <= 1'b0;
    end else if (strobes.wrCfgHi) begin
      stopBit <= regWrData[STOP_POS];
      haltBit <= regWrData[HALT_POS];
      if (badStop)                 errBit <= 1'b1;
      else if (regWrData[ERR_POS]) errBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrLvl <= '0;
      intrVec <= '0;
    end else begin
      if (strobes.wrIntrHi) intrLvl <= regWrData[8 +: LVL_W];
      if (strobes.wrIntrLo) intrVec <= regWrData[0 +: VEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrRamHi) queueMem[ramIdx][15:8] <= regWrData[15:8];
    if (strobes.wrRamLo) queueMem[ramIdx][7:0]  <= regWrData[7:0];
  end

  always_comb begin
    regRdData = '0;
    if (strobes.rdCfg) begin
      regRdData[STOP_POS] = stopBit;
      regRdData[HALT_POS] = haltBit;
      regRdData[ERR_POS]  = errBit;
    end else if (strobes.rdIntr) begin
      regRdData[8 +: LVL_W] = intrLvl;
      regRdData[0 +: VEC_W] = intrVec;
    end else if (strobes.rdRam) begin
      regRdData = queueMem[ramIdx];
    end
  end

  assign stopNow    = stopBit;
  assign haltReq    = haltBit;
  assign stopErrNow = errBit;
endmodule

// File: rtl/serStopGate.sv
module serStopGate (
  input  logic clk,
  input  logic rstN,
  input  logic enReq,
  output logic gateEn,
  output logic gatedClk
);
  // enable taken over while clk is low, so the AND below cannot glitch
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= enReq;
  end

  assign gatedClk = clk & gateEn;
endmodule

// File: rtl/serStopCtl.sv
module serStopCtl
  import serStopPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int RAM_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regByteEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              engineBusy,
  input  logic              haltAck,
  output logic              haltReq,
  output logic              gatedClk
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  ctlStrobeT         strobes;
  logic [RAM_AW-1:0] ramIdx;
  logic              stopNow;
  logic              stopErrNow;
  logic              gateEn;

  serStopDecode #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH)) i_decode (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .stopNow(stopNow),
    .strobes(strobes), .ramIdx(ramIdx)
  );

  serStopRegs #(.RAM_DEPTH(RAM_DEPTH)) i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ramIdx(ramIdx),
    .regWrData(regWrData), .engineBusy(engineBusy), .haltAck(haltAck),
    .regRdData(regRdData), .stopNow(stopNow), .haltReq(haltReq),
    .stopErrNow(stopErrNow)
  );

  serStopGate i_gate (
    .clk(clk), .rstN(rstN), .enReq(!stopNow),
    .gateEn(gateEn), .gatedClk(gatedClk)
  );
endmodule

// File: rtl/serStopChk.sv
module serStopChk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [1:0]        regByteEn,
  input logic [15:0]       regWrData,
  input logic [15:0]       regRdData,
  input logic              engineBusy,
  input logic              haltAck,
  input logic              haltReq,
  input logic              gatedClk,
  input logic              stopNow,
  input logic              stopErrNow,
  input logic              gateEn
);
  logic cfgHiWr;
  assign cfgHiWr = regWrEn && (regAddr == ADDR_W'(0)) && regByteEn[1];

  p_cfg_spare_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(0)) |-> (regRdData[12:0] == 13'd0));

  p_stop_rd_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && stopNow && regAddr != ADDR_W'(0)) |-> (regRdData == 16'd0));

  p_halt_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgHiWr |=> (haltReq == $past(regWrData[14])));

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHiWr && !stopNow && regWrData[15] && engineBusy && !haltAck) |=> stopErrNow);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopErrNow && !cfgHiWr) |=> stopErrNow);

  p_gate_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    gateEn == !stopNow);

  always_comb begin
    if (!clk) p_gate_low_r8: assert (!gatedClk);
  end
endmodule

bind serStopCtl serStopChk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regByteEn(regByteEn), .regWrData(regWrData),
  .regRdData(regRdData), .engineBusy(engineBusy), .haltAck(haltAck),
  .haltReq(haltReq), .gatedClk(gatedClk), .stopNow(stopNow),
  .stopErrNow(stopErrNow), .gateEn(gateEn)
);

// File: tb/test_serStopCtl.sv
module test_serStopCtl;
  localparam int CLK_P     = 10;
  localparam int ADDR_W    = 6;
  localparam int RAM_DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [1:0]  regByteEn = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        engineBusy = 1'b0;
  logic        haltAck = 1'b0;
  logic        haltReq;
  logic        gatedClk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  serStopCtl #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH)) i_serStopCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWrData(regWrData),
    .regRdData(regRdData), .engineBusy(engineBusy), .haltAck(haltAck),
    .haltReq(haltReq), .gatedClk(gatedClk)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model
  bit        stopM, haltM, errM, gateM;
  bit [2:0]  lvlM;
  bit [7:0]  vecM;
  bit [15:0] ramM [RAM_DEPTH];

  function automatic bit isRamAddr(input logic [5:0] a);
    return a[5] && (int'(a[4:0]) < RAM_DEPTH);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopM = 1; haltM = 0; errM = 0; lvlM = 0; vecM = 0;
    end else if (regWrEn) begin
      if (regAddr == 0 && regByteEn[1]) begin
        if (!stopM && regWrData[15] && engineBusy && !haltAck) errM = 1;
        else if (regWrData[13]) errM = 0;
        stopM = regWrData[15];
        haltM = regWrData[14];
      end else if (regAddr == 1) begin
        if (regByteEn[1]) lvlM = regWrData[10:8];
        if (regByteEn[0]) vecM = regWrData[7:0];
      end else if (isRamAddr(regAddr)) begin
        if (regByteEn[1]) ramM[regAddr[3:0]][15:8] = regWrData[15:8];
        if (regByteEn[0]) ramM[regAddr[3:0]][7:0]  = regWrData[7:0];
      end
    end
  end

  always @(negedge clk or negedge rstN) begin
    if (!rstN) gateM = 0;
    else       gateM = !stopM;
  end

  function automatic logic [15:0] expRead();
    if (!regRdEn)        return 16'h0;
    if (regAddr == 0)    return {stopM, haltM, errM, 13'h0};
    if (stopM)           return 16'h0;
    if (regAddr == 1)    return {5'h0, lvlM, vecM};
    if (isRamAddr(regAddr)) return ramM[regAddr[3:0]];
    return 16'h0;
  endfunction

  function automatic string tagFor();
    if (regAddr == 0)       return "R2";
    if (stopM)              return "R3";
    if (regAddr == 1)       return "R5";
    if (isRamAddr(regAddr)) return "R9";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, late in the low phase
  always @(negedge clk) begin
    #(CLK_P/2 - 1);
    if (rstN && !done) begin
      check(tagFor(), regRdData, expRead());
      check("R6", 16'(haltReq), 16'(haltM));
      check("R8", 16'(gatedClk), 16'h0);
    end
  end

  // gated clock during the high phase
  always @(posedge clk) begin
    #1;
    if (!done) check("R8", 16'(gatedClk), 16'(gateM));
  end

  task automatic cyc(input bit we, input bit re, input logic [5:0] a,
                     input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = d; regByteEn = be;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    cyc(1, 0, a, d, be);
  endtask

  task automatic rdChk(input logic [5:0] a, input logic [15:0] exp, input string tag);
    cyc(0, 1, a, 16'h0, 2'b00);
    #(CLK_P/2 - 2);
    check(tag, regRdData, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; check("R1", 16'(gatedClk), 16'h0);
    @(negedge clk); rstN = 1;
    rdChk(0, 16'h8000, "R1");
    rdChk(1, 16'h0000, "R1");
    rdChk(1, 16'h0000, "R3");
    wr(1, 16'hFF5A, 2'b11);
    wr(35, 16'h1234, 2'b11);
    rdChk(35, 16'h0000, "R3");
    rdChk(50, 16'h0000, "R3");
    wr(0, 16'h0000, 2'b10);
    rdChk(1, 16'h075A, "R4");
    rdChk(35, 16'h1234, "R4");
    wr(1, 16'h0300, 2'b10);
    rdChk(1, 16'h035A, "R5");
    wr(1, 16'hFFC3, 2'b01);
    rdChk(1, 16'h03C3, "R5");
    for (int i = 0; i < RAM_DEPTH; i++) wr(6'(32 + i), 16'(i * 16'h1111), 2'b11);
    wr(47, 16'hBEEF, 2'b11);
    wr(47, 16'h0011, 2'b01);
    rdChk(47, 16'hBE11, "R9");
    rdChk(48, 16'h0000, "R2");
    wr(0, 16'hFFFF, 2'b10);
    rdChk(0, 16'hC000, "R2");
    wr(0, 16'h4000, 2'b10);
    rdChk(0, 16'h4000, "R6");
    engineBusy = 1; haltAck = 0;
    wr(0, 16'hC000, 2'b10);
    rdChk(0, 16'hE000, "R7");
    wr(0, 16'h0000, 2'b01);
    rdChk(0, 16'hE000, "R2");
    wr(0, 16'h2000, 2'b10);
    rdChk(0, 16'h0000, "R7");
    haltAck = 1;
    wr(0, 16'h8000, 2'b10);
    rdChk(0, 16'h8000, "R7");
    repeat (3) cyc(0, 0, 0, 0, 0);
    wr(0, 16'h0000, 2'b10);
    repeat (3) cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      logic [5:0] a;
      case (r[2:0])
        3'd0, 3'd1: a = 6'd0;
        3'd2, 3'd3: a = 6'd1;
        3'd4:       a = 6'd7;
        3'd5:       a = 6'd52;
        default:    a = 6'(32 + r[11:8]);
      endcase
      engineBusy = r[20];
      haltAck    = r[21];
      cyc(r[3], r[4], a, r[31:16] ^ 16'(r[15:12] * 16'h0A01), r[6:5]);
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule